// File: doc/BRIEF.md
# Lockable Watchdog Timer

A 32-bit down-counting timer on a word-wide register bus that can be switched into a locked watchdog mode. The block has a reload value register, a readable counter, a control register, a status register and a separate unlock register. A programmable 8-bit prescaler divides the clock. The counter steps down once per prescaled tick. Software refreshes the watchdog by writing the reload value again. That write copies the value into the counter and restarts the prescaler.

The block has two modes. In timer mode, the counter reaching zero reloads it from the reload register and raises an interrupt flag. In watchdog mode, the same event reloads the counter, pulses a reset request for one clock and sets a sticky reset-status bit. Once watchdog mode is set, a control write cannot clear it. Only a two-word key sequence written to the unlock register returns the block to timer mode.

The key sequence is tracked by a three-state machine:
- UL_IDLE: waiting for the first key (0x12345678). The first key moves it to UL_HALF. Any other value keeps it in UL_IDLE.
- UL_HALF: the first key has been seen. The second key (0x87654321) moves it to UL_OPEN. Any other value returns it to UL_IDLE.
- UL_OPEN: lasts exactly one clock and clears the mode bit. It then goes to UL_IDLE, or to UL_HALF if that same cycle carries a new first key.

Writes to other registers do not move the tracker.

Top module: `wdog_lockout_timer`

## Requirements
- R1: After reset, every register reads 0 (reload at 0x00, counter at 0x04, control at 0x08, status at 0x0C), and `rst_req_o` and `irq_o` are low.
- R2: A write to offset 0x00 stores the reload value and copies it into the counter in the same clock. It also restarts the prescaler, so the countdown starts afresh.
- R3: Control bit 0 is enable and control bits [15:8] are the prescale field P. With reload value N and enable set at clock edge e0 (or a reload write at e0 while enabled), the counter reaches its terminal event at edge e0 + (P+1)*(N+1).
- R4: While control bit 0 is 0, the counter holds its value.
- R5: Control bit 1 is the watchdog-mode bit. Writing 1 to it sets it. Writing 0 to it through the control register leaves it set, while enable and prescale still update from the same write.
- R6: Writing 0x12345678 and then 0x87654321 to offset 0x14 clears the watchdog-mode bit. The cleared bit is visible one clock after the edge that took the second word.
- R7: Any other value written to offset 0x14 returns the tracker to UL_IDLE. This includes a repeated first key while in UL_HALF. The sequence must then start again from the first key.
- R8: In watchdog mode, the terminal event pulses `rst_req_o` high for one clock, in the cycle after the edge of the event. It also sets status bit 1 and does not set status bit 0.
- R9: In timer mode, the terminal event reloads the counter from the reload register and sets status bit 0. `irq_o` follows status bit 0. `rst_req_o` stays low.
- R10: Status bits 0 and 1 are cleared by writing 1 to them. Writing 0 to a status bit leaves it unchanged.
- R11: The counter register at 0x04 is read-only. A write to it leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one register per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req_o | output | 1 | One-clock reset request on watchdog expiry |
| irq_o | output | 1 | Timer-mode expiry flag (status bit 0) |

## Verification
The assertions assume that reset is asserted before the first write. They also assume that at most one register write arrives per clock, with address and data stable across the write edge. The stimulus drives the bus only on falling clock edges. It holds the strobe through exactly one rising edge per write and samples results one time unit after a rising edge, or at the following falling edge. Timing checks begin by disabling the count, clearing status and loading the counter, so every expiry cycle counted from the enabling edge is fixed in advance.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_HALF = 2'd1,
        UL_OPEN = 2'd2
    } unlock_state_e;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_WD_BIT    = 1;
    localparam int CTRL_PRE_LSB   = 8;
    localparam int STAT_TMR_BIT   = 0;
    localparam int STAT_RST_BIT   = 1;

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [PRE_W-1:0] ratio_i,
    output logic             tick_o
);
    logic [PRE_W-1:0] div_q;

    assign tick_o = en_i && (div_q >= ratio_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (!en_i || restart_i || tick_o)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    // divider never runs while the count is off
    p_idle_divider_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> div_q == '0);

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              load_wr_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic [DATA_W-1:0] reload_val_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic              expire_o
);
    logic [DATA_W-1:0] cnt_q;

    assign cnt_o    = cnt_q;
    assign expire_o = tick_i && !load_wr_i && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_wr_i)
            cnt_q <= load_val_i;
        else if (tick_i)
            cnt_q <= (cnt_q == '0) ? reload_val_i : cnt_q - 1'b1;
    end

    p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr_i |=> cnt_q == $past(load_val_i));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_wr_i) |=> $stable(cnt_q));

    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_wr_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> cnt_q == $past(reload_val_i));

endmodule

// File: rtl/wdog_unlock_fsm.sv
module wdog_unlock_fsm
    import wdog_pkg::*;
#(
    parameter int              DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY_A = 32'h1234_5678,
    parameter logic [DATA_W-1:0] KEY_B = 32'h8765_4321
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              clear_o
);
    unlock_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= UL_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UL_IDLE: begin
                if (wr_i && data_i == KEY_A)
                    state_d = UL_HALF;
            end
            UL_HALF: begin
                if (wr_i)
                    state_d = (data_i == KEY_B) ? UL_OPEN : UL_IDLE;
            end
            UL_OPEN: begin
                state_d = (wr_i && data_i == KEY_A) ? UL_HALF : UL_IDLE;
            end
            default: state_d = UL_IDLE;
        endcase
    end

    always_comb begin
        clear_o = (state_q == UL_OPEN);
    end

    p_open_needs_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == UL_OPEN |-> $past(state_q) == UL_HALF);

    p_bad_word_resets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UL_HALF && wr_i && data_i != KEY_B) |=> state_q == UL_IDLE);

endmodule

// File: rtl/wdog_lockout_timer.sv
module wdog_lockout_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int PRE_W  = 8,
    parameter logic [DATA_W-1:0] KEY_A = 32'h1234_5678,
    parameter logic [DATA_W-1:0] KEY_B = 32'h8765_4321
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] OFS_LOAD = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] OFS_KEY  = ADDR_W'(8'h14);

    logic              wr_load, wr_ctrl, wr_stat, wr_key;
    logic [DATA_W-1:0] load_q, cnt;
    logic              en_q, wd_q, tmr_flag_q, rst_flag_q, rst_req_q;
    logic [PRE_W-1:0]  pre_q;
    logic              tick, expire, unlock_clr;

    assign wr_load = bus_wr && (bus_addr == OFS_LOAD);
    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
    assign wr_key  = bus_wr && (bus_addr == OFS_KEY);

    wdog_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_q),
        .restart_i (wr_load),
        .ratio_i   (pre_q),
        .tick_o    (tick)
    );

    wdog_countdown #(.DATA_W(DATA_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_q),
        .tick_i       (tick),
        .load_wr_i    (wr_load),
        .load_val_i   (bus_wdata),
        .reload_val_i (load_q),
        .cnt_o        (cnt),
        .expire_o     (expire)
    );

    wdog_unlock_fsm #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_key),
        .data_i  (bus_wdata),
        .clear_o (unlock_clr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q     <= '0;
            en_q       <= 1'b0;
            wd_q       <= 1'b0;
            pre_q      <= '0;
            tmr_flag_q <= 1'b0;
            rst_flag_q <= 1'b0;
            rst_req_q  <= 1'b0;
        end else begin
            if (wr_load)
                load_q <= bus_wdata;
            if (wr_ctrl) begin
                en_q  <= bus_wdata[CTRL_EN_BIT];
                pre_q <= bus_wdata[CTRL_PRE_LSB +: PRE_W];
            end
            if (wr_ctrl && bus_wdata[CTRL_WD_BIT])
                wd_q <= 1'b1;
            else if (unlock_clr)
                wd_q <= 1'b0;
            tmr_flag_q <= (tmr_flag_q && !(wr_stat && bus_wdata[STAT_TMR_BIT]))
                          || (expire && !wd_q);
            rst_flag_q <= (rst_flag_q && !(wr_stat && bus_wdata[STAT_RST_BIT]))
                          || (expire && wd_q);
            rst_req_q  <= expire && wd_q;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_LOAD: bus_rdata = load_q;
            OFS_CNT:  bus_rdata = cnt;
            OFS_CTRL: begin
                bus_rdata[CTRL_EN_BIT]              = en_q;
                bus_rdata[CTRL_WD_BIT]              = wd_q;
                bus_rdata[CTRL_PRE_LSB +: PRE_W]    = pre_q;
            end
            OFS_STAT: begin
                bus_rdata[STAT_TMR_BIT] = tmr_flag_q;
                bus_rdata[STAT_RST_BIT] = rst_flag_q;
            end
            default:  bus_rdata = '0;
        endcase
    end

    assign rst_req_o = rst_req_q;
    assign irq_o     = tmr_flag_q;

    p_wd_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_q) |-> $past(unlock_clr));

    p_rst_wd_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(wd_q));

    p_irq_timer_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_flag_q) |-> $past(!wd_q));

    p_rst_flag_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> rst_flag_q);

endmodule

// File: tb/wdog_lockout_timer_tb_top.sv
module wdog_lockout_timer_tb_top;
    localparam logic [7:0] A_LOAD = 8'h00;
    localparam logic [7:0] A_CNT  = 8'h04;
    localparam logic [7:0] A_CTRL = 8'h08;
    localparam logic [7:0] A_STAT = 8'h0C;
    localparam logic [7:0] A_KEY  = 8'h14;
    localparam logic [31:0] KA = 32'h1234_5678;
    localparam logic [31:0] KB = 32'h8765_4321;

    // {prescale P, reload N, expected clocks (P+1)*(N+1)}
    localparam int NV = 6;
    localparam logic [31:0] VEC [NV][3] = '{
        '{32'd0,   32'd0, 32'd1},
        '{32'd0,   32'd3, 32'd4},
        '{32'd1,   32'd2, 32'd6},
        '{32'd3,   32'd4, 32'd20},
        '{32'd7,   32'd1, 32'd16},
        '{32'd255, 32'd0, 32'd256}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdog_lockout_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req_o(rst_req_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; #1;
        d = bus_rdata;
    endtask

    task automatic wait_out(input bit use_rst, output int n);
        n = 0;
        for (int i = 1; i <= 600; i++) begin
            @(posedge clk); #1;
            if ((use_rst ? rst_req_o : irq_o) === 1'b1) begin
                n = i;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(A_LOAD, v); check("R1 load", v, 0);
        rd(A_CNT,  v); check("R1 count", v, 0);
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_STAT, v); check("R1 status", v, 0);
        check("R1 outputs", {30'd0, rst_req_o, irq_o}, 0);

        // R2/R3/R9 timer-mode timing table
        for (int k = 0; k < NV; k++) begin
            wr(A_CTRL, 32'h0);
            wr(A_STAT, 32'h3);
            wr(A_LOAD, VEC[k][1]);
            wr(A_CTRL, (VEC[k][0] << 8) | 32'h1);
            wait_out(1'b0, n);
            check("R3 timer expiry cycle", n, VEC[k][2]);
            rd(A_CNT, v); check("R9 reload after expiry", v, VEC[k][1]);
            check("R9 no reset request", {31'd0, rst_req_o}, 0);
        end
        rd(A_STAT, v); check("R9 status bit0", v, 32'h1);

        // R10 write-0 keeps, write-1 clears
        wr(A_STAT, 32'h0); rd(A_STAT, v); check("R10 write zero keeps", v, 32'h1);
        wr(A_STAT, 32'h1); rd(A_STAT, v); check("R10 write one clears", v, 32'h0);

        // R4 hold and R11 read-only counter
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'd100);
        repeat (10) @(posedge clk);
        rd(A_CNT, v); check("R4 hold while disabled", v, 100);
        wr(A_CNT, 32'd5);
        rd(A_CNT, v); check("R11 counter read-only", v, 100);

        // R8 watchdog expiry
        wr(A_STAT, 32'h3);
        wr(A_LOAD, 32'd5);
        wr(A_CTRL, 32'h3);
        wait_out(1'b1, n);
        check("R8 watchdog expiry cycle", n, 6);
        check("R8 no irq in watchdog mode", {31'd0, irq_o}, 0);
        @(posedge clk); #1;
        check("R8 one-clock pulse", {31'd0, rst_req_o}, 0);
        rd(A_STAT, v); check("R8 status bit1", v, 32'h2);
        wr(A_STAT, 32'h2); rd(A_STAT, v); check("R10 clear reset status", v, 0);

        // R2 refresh by reload write
        wr(A_LOAD, 32'd5);
        for (int j = 0; j < 3; j++) begin
            @(posedge clk); #1;
            check("R2 no expiry before refresh", {31'd0, rst_req_o}, 0);
        end
        wr(A_LOAD, 32'd5);
        wait_out(1'b1, n);
        check("R2 refresh restarts countdown", n, 6);

        // R5 control write cannot leave watchdog mode
        wr(A_CTRL, 32'h0000_0701);
        rd(A_CTRL, v); check("R5 mode bit sticky", v, 32'h0000_0703);

        // R7 broken sequences
        wr(A_KEY, KA); wr(A_KEY, 32'hDEAD_BEEF); wr(A_KEY, KB);
        repeat (2) @(posedge clk);
        rd(A_CTRL, v); check("R7 wrong second word", v[1], 1'b1);
        wr(A_KEY, KA); wr(A_KEY, KA); wr(A_KEY, KB);
        repeat (2) @(posedge clk);
        rd(A_CTRL, v); check("R7 repeated first word", v[1], 1'b1);
        wr(A_KEY, KB); wr(A_KEY, KA); wr(A_KEY, 32'h0); wr(A_KEY, KB);
        repeat (2) @(posedge clk);
        rd(A_CTRL, v); check("R7 reversed order", v[1], 1'b1);

        // R6 valid sequence, cleared one clock later
        wr(A_KEY, KA); wr(A_KEY, KB);
        rd(A_CTRL, v); check("R6 still set in accept cycle", v[1], 1'b1);
        rd(A_CTRL, v); check("R6 mode cleared", v, 32'h0000_0701);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule